// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File with Bank Decode

This block is the set of configuration registers for an SDRAM controller. Software reaches it through two device-control-register numbers. A write to the pointer port stores a register offset. A read or write on the window port then reaches the register that the stored offset selects. The registers are:

- two error status words, cleared by writing ones;
- an error address;
- a configuration word;
- a status word that software can only read;
- refresh and idle timers;
- a timing word;
- ECC configuration;
- ECC error status;
- one configuration word per memory bank.

Each register keeps only its writable bits. The status word records the edges of the configuration enable bits.

Each bank word also encodes a base address, a size code and an enable. The block turns these into address windows. It compares an incoming system address with every window and reports at most one bank hit, and the lowest bank index wins. A level interrupt stays high for as long as any masked ECC error status bit is set. The command sequencer, the refresh engine and the data path are outside this block.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write strobe on DCR number 0x010 stores the full 32-bit write data as the register offset. A read strobe on 0x010 returns the stored offset. Read data for any read strobe appears on `rdData` in the cycle after the strobe.
- R2: A read strobe on DCR number 0x011 returns the register at the stored offset. Offset 0x80 (timing) and any offset that maps to no register return 0xFFFFFFFF. A read strobe on any other DCR number returns zero.
- R3: After reset, the registers hold these values: configuration (0x20) 0x00800000, refresh timer (0x30) 0x05F00000, idle timer (0x34) 0x07C00000. All other readable registers and the stored offset are zero, and `eccIrq` is low.
- R4: The error status words at offsets 0x00 and 0x08 are write-one-to-clear. A write to either one clears the bits written as one. No window write sets a bit, so after reset they read zero.
- R5: The status word at offset 0x24 ignores writes. It changes only as a side effect of configuration writes.
- R6: A configuration write keeps bits 31:21 of the data and clears bits 20:0.
- R7: A configuration write that takes bit 31 from 0 to 1 clears status bit 31. A write that takes bit 31 from 1 to 0 sets status bit 31. A write that leaves bit 31 unchanged leaves status bit 31 unchanged.
- R8: A configuration write that takes bit 30 from 0 to 1 sets status bit 30. A write that takes bit 30 from 1 to 0 clears status bit 30.
- R9: Writes are stored masked as follows: refresh timer (0x30) with 0x3FF80000, ECC configuration (0x94) with 0x00F00000, error address (0x10) unmasked. The idle timer (0x34) stores bits 31:27 of the data and always reads ones in bits 26:22.
- R10: ECC error status (0x98) stores the data masked with 0xFFF0F000. `eccIrq` is high exactly while this register is nonzero, from the cycle after the write.
- R11: Bank word i (offset 0x40 + 4*i, i = 0..3) stores the data masked with 0xFFDEE001. Bit 0 is the bank enable, bits 31:23 are the base address bits 31:23, and bits 19:17 are a size code.
- R12: Bank hit bit i is set only when all of these hold:
  - configuration bit 31 is one;
  - the bank enable is one;
  - the size code c is not 7;
  - `sysAddr` lies in the range base <= `sysAddr` < base + (4 MiB << c), computed without 32-bit wrap.
- R13: `bankHit` has at most one bit set. When several banks match, only the lowest index is reported. A bank with size code 7 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dcrNum | input | 10 | Device-control-register number of the access |
| rdStb | input | 1 | Single-cycle read strobe |
| wrStb | input | 1 | Single-cycle write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data, valid the cycle after `rdStb` |
| sysAddr | input | 32 | System address to decode |
| bankHit | output | 4 | One-hot bank match, lowest index first |
| eccIrq | output | 1 | ECC error interrupt level |

## Verification
The hardest condition to produce from the ports is several enabled banks that overlap. An address must then fall inside some of them while the global enable is also set. Random bank words alone almost never produce this. The bench therefore places hand-built overlapping windows and a window reaching the top of the address space. It probes each window exactly at base - 1, at base, at its last byte and at its end. The random phase draws probe addresses as a bank's base plus a random distance, so every probe lands near a window. It also toggles the configuration enable bits to exercise the status edges.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

  localparam int DW         = 32;
  localparam int BANK_IDX_W = 4;

  // register offsets seen through the window port
  localparam logic [DW-1:0] OFF_ERR0    = 32'h00;
  localparam logic [DW-1:0] OFF_ERR1    = 32'h08;
  localparam logic [DW-1:0] OFF_ERRADDR = 32'h10;
  localparam logic [DW-1:0] OFF_CFG     = 32'h20;
  localparam logic [DW-1:0] OFF_STAT    = 32'h24;
  localparam logic [DW-1:0] OFF_RFSH    = 32'h30;
  localparam logic [DW-1:0] OFF_IDLE    = 32'h34;
  localparam logic [DW-1:0] OFF_BANK0   = 32'h40;
  localparam logic [DW-1:0] OFF_TIMING  = 32'h80;
  localparam logic [DW-1:0] OFF_ECCCFG  = 32'h94;
  localparam logic [DW-1:0] OFF_ECCST   = 32'h98;

  // write masks
  localparam logic [DW-1:0] CFG_MASK    = 32'hFFE0_0000;
  localparam logic [DW-1:0] RFSH_MASK   = 32'h3FF8_0000;
  localparam logic [DW-1:0] IDLE_MASK   = 32'hF800_0000;
  localparam logic [DW-1:0] IDLE_FORCE  = 32'h07C0_0000;
  localparam logic [DW-1:0] ECCCFG_MASK = 32'h00F0_0000;
  localparam logic [DW-1:0] ECCST_MASK  = 32'hFFF0_F000;
  localparam logic [DW-1:0] BANK_MASK   = 32'hFFDE_E001;

  // reset values
  localparam logic [DW-1:0] CFG_RST     = 32'h0080_0000;
  localparam logic [DW-1:0] RFSH_RST    = 32'h05F0_0000;
  localparam logic [DW-1:0] IDLE_RST    = 32'h07C0_0000;

  // control bits
  localparam int CFG_EN_BIT   = 31;
  localparam int CFG_AUX_BIT  = 30;

  // bank word fields
  localparam int BASE_LSB      = 23;
  localparam int BASE_W        = DW - BASE_LSB;
  localparam int SIZE_LSB      = 17;
  localparam int SIZE_W        = 3;
  localparam int MIN_SIZE_LOG2 = 22;
  localparam logic [SIZE_W-1:0] SIZE_BAD = '1;

  typedef enum logic [3:0] {
    SEL_ERR0, SEL_ERR1, SEL_ERRADDR, SEL_CFG, SEL_STAT, SEL_RFSH, SEL_IDLE,
    SEL_BANK, SEL_TIMING, SEL_ECCCFG, SEL_ECCST, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic                  dataWr;
    logic                  dataRd;
    logic                  addrRd;
    logic                  anyRd;
    regSel_e               sel;
    logic [BANK_IDX_W-1:0] bankIdx;
  } cfgStrobe_t;

endpackage

// File: rtl/sdram_cfg_ctrl.sv
module sdram_cfg_ctrl
  import sdram_cfg_pkg::*;
#(
  parameter int                DCR_AW    = 10,
  parameter logic [DCR_AW-1:0] ADDR_PORT = 10'h010,
  parameter int                NUM_BANKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DCR_AW-1:0] dcrNum,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [DW-1:0]     wrData,
  output logic [DW-1:0]     offset,
  output cfgStrobe_t        stb
);

  localparam logic [DCR_AW-1:0] DATA_PORT = ADDR_PORT + DCR_AW'(1);
  localparam logic [DW-1:0]     BANK_END  = OFF_BANK0 + DW'(4 * NUM_BANKS);

  logic hitAddr;
  logic hitData;

  assign hitAddr = (dcrNum == ADDR_PORT);
  assign hitData = (dcrNum == DATA_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset <= '0;
    end else if (wrStb && hitAddr) begin
      offset <= wrData;
    end
  end

  always_comb begin
    stb.dataWr  = wrStb && hitData;
    stb.dataRd  = rdStb && hitData;
    stb.addrRd  = rdStb && hitAddr;
    stb.anyRd   = rdStb;
    stb.bankIdx = '0;
    case (offset)
      OFF_ERR0:    stb.sel = SEL_ERR0;
      OFF_ERR1:    stb.sel = SEL_ERR1;
      OFF_ERRADDR: stb.sel = SEL_ERRADDR;
      OFF_CFG:     stb.sel = SEL_CFG;
      OFF_STAT:    stb.sel = SEL_STAT;
      OFF_RFSH:    stb.sel = SEL_RFSH;
      OFF_IDLE:    stb.sel = SEL_IDLE;
      OFF_TIMING:  stb.sel = SEL_TIMING;
      OFF_ECCCFG:  stb.sel = SEL_ECCCFG;
      OFF_ECCST:   stb.sel = SEL_ECCST;
      default: begin
        if (offset >= OFF_BANK0 && offset < BANK_END && offset[1:0] == 2'b00) begin
          stb.sel     = SEL_BANK;
          stb.bankIdx = offset[2 +: BANK_IDX_W];
        end else begin
          stb.sel = SEL_NONE;
        end
      end
    endcase
  end

  // R1
  offset_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrStb && hitAddr |=> offset == $past(wrData));

endmodule

// File: rtl/sdram_bank_match.sv
module sdram_bank_match
  import sdram_cfg_pkg::*;
(
  input  logic              globalEn,
  input  logic              bankEn,
  input  logic [BASE_W-1:0] baseField,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [DW-1:0]     sysAddr,
  output logic              hit
);

  localparam int XW = DW + 1;

  logic [XW-1:0] baseX;
  logic [XW-1:0] sizeX;
  logic [XW-1:0] limitX;
  logic [XW-1:0] addrX;

  assign baseX  = {1'b0, baseField, {BASE_LSB{1'b0}}};
  assign sizeX  = (XW'(1) << MIN_SIZE_LOG2) << sizeCode;
  assign limitX = baseX + sizeX;
  assign addrX  = {1'b0, sysAddr};

  assign hit = globalEn && bankEn && (sizeCode != SIZE_BAD) &&
               (addrX >= baseX) && (addrX < limitX);

endmodule

// File: rtl/sdram_cfg_dpath.sv
module sdram_cfg_dpath
  import sdram_cfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cfgStrobe_t           stb,
  input  logic [DW-1:0]        wrData,
  input  logic [DW-1:0]        offset,
  input  logic [DW-1:0]        sysAddr,
  output logic [DW-1:0]        rdData,
  output logic [NUM_BANKS-1:0] bankHit,
  output logic                 eccIrq
);

  logic [DW-1:0] err0R, err1R, errAddrR, cfgR, statR, rfshR, idleR, eccCfgR, eccStR;
  logic [DW-1:0] bankR [NUM_BANKS];
  logic [DW-1:0] bankRd;
  logic [DW-1:0] rdNext;
  logic [NUM_BANKS-1:0] rawHit;
  logic cfgWr;

  assign cfgWr = stb.dataWr && (stb.sel == SEL_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err0R    <= '0;
      err1R    <= '0;
      errAddrR <= '0;
      cfgR     <= CFG_RST;
      statR    <= '0;
      rfshR    <= RFSH_RST;
      idleR    <= IDLE_RST;
      eccCfgR  <= '0;
      eccStR   <= '0;
    end else if (stb.dataWr) begin
      case (stb.sel)
        SEL_ERR0:    err0R    <= err0R & ~wrData;
        SEL_ERR1:    err1R    <= err1R & ~wrData;
        SEL_ERRADDR: errAddrR <= wrData;
        SEL_CFG: begin
          cfgR <= wrData & CFG_MASK;
          if (!cfgR[CFG_EN_BIT] && wrData[CFG_EN_BIT])
            statR[CFG_EN_BIT] <= 1'b0;
          else if (cfgR[CFG_EN_BIT] && !wrData[CFG_EN_BIT])
            statR[CFG_EN_BIT] <= 1'b1;
          if (!cfgR[CFG_AUX_BIT] && wrData[CFG_AUX_BIT])
            statR[CFG_AUX_BIT] <= 1'b1;
          else if (cfgR[CFG_AUX_BIT] && !wrData[CFG_AUX_BIT])
            statR[CFG_AUX_BIT] <= 1'b0;
        end
        SEL_RFSH:    rfshR   <= wrData & RFSH_MASK;
        SEL_IDLE:    idleR   <= (wrData & IDLE_MASK) | IDLE_FORCE;
        SEL_ECCCFG:  eccCfgR <= wrData & ECCCFG_MASK;
        SEL_ECCST:   eccStR  <= wrData & ECCST_MASK;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bankR[i] <= '0;
      end else if (stb.dataWr && stb.sel == SEL_BANK && stb.bankIdx == BANK_IDX_W'(i)) begin
        bankR[i] <= wrData & BANK_MASK;
      end
    end

    sdram_bank_match u_match (
      .globalEn (cfgR[CFG_EN_BIT]),
      .bankEn   (bankR[i][0]),
      .baseField(bankR[i][DW-1:BASE_LSB]),
      .sizeCode (bankR[i][SIZE_LSB +: SIZE_W]),
      .sysAddr  (sysAddr),
      .hit      (rawHit[i])
    );
  end

  // keep only the lowest set bit
  assign bankHit = rawHit & (~rawHit + NUM_BANKS'(1));
  assign eccIrq  = |eccStR;

  always_comb begin
    bankRd = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (stb.bankIdx == BANK_IDX_W'(b)) bankRd = bankR[b];
    end
    if (stb.addrRd) begin
      rdNext = offset;
    end else if (stb.dataRd) begin
      case (stb.sel)
        SEL_ERR0:    rdNext = err0R;
        SEL_ERR1:    rdNext = err1R;
        SEL_ERRADDR: rdNext = errAddrR;
        SEL_CFG:     rdNext = cfgR;
        SEL_STAT:    rdNext = statR;
        SEL_RFSH:    rdNext = rfshR;
        SEL_IDLE:    rdNext = idleR;
        SEL_BANK:    rdNext = bankRd;
        SEL_ECCCFG:  rdNext = eccCfgR;
        SEL_ECCST:   rdNext = eccStR;
        default:     rdNext = '1;
      endcase
    end else begin
      rdNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (stb.anyRd) begin
      rdData <= rdNext;
    end
  end

  // R1
  addr_port_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.addrRd |=> rdData == $past(offset));

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgWr |=> $stable(statR));

  // R7
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWr && !cfgR[CFG_EN_BIT] && wrData[CFG_EN_BIT] |=> !statR[CFG_EN_BIT]);

  // R10
  ecc_irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.dataWr && stb.sel == SEL_ECCST && (wrData & ECCST_MASK) != '0 |=> eccIrq);

  // R12
  hit_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgR[CFG_EN_BIT] |-> bankHit == '0);

  // R13
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bankHit));

endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int                DCR_AW    = 10,
  parameter logic [DCR_AW-1:0] ADDR_PORT = 10'h010,
  parameter int                NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DCR_AW-1:0]    dcrNum,
  input  logic                 rdStb,
  input  logic                 wrStb,
  input  logic [DW-1:0]        wrData,
  output logic [DW-1:0]        rdData,
  input  logic [DW-1:0]        sysAddr,
  output logic [NUM_BANKS-1:0] bankHit,
  output logic                 eccIrq
);

  cfgStrobe_t    stb;
  logic [DW-1:0] offset;

  sdram_cfg_ctrl #(
    .DCR_AW   (DCR_AW),
    .ADDR_PORT(ADDR_PORT),
    .NUM_BANKS(NUM_BANKS)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .dcrNum(dcrNum),
    .rdStb (rdStb),
    .wrStb (wrStb),
    .wrData(wrData),
    .offset(offset),
    .stb   (stb)
  );

  sdram_cfg_dpath #(
    .NUM_BANKS(NUM_BANKS)
  ) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wrData (wrData),
    .offset (offset),
    .sysAddr(sysAddr),
    .rdData (rdData),
    .bankHit(bankHit),
    .eccIrq (eccIrq)
  );

endmodule

// File: tb/sim_sdram_cfg_regs.sv
module sim_sdram_cfg_regs;

  localparam logic [9:0] PTR = 10'h010;
  localparam logic [9:0] WIN = 10'h011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  dcrNum = '0;
  logic        rdStb = 1'b0;
  logic        wrStb = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] sysAddr = '0;
  logic [3:0]  bankHit;
  logic        eccIrq;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;

  logic [31:0] mOffset, mErrAddr, mCfg, mStat, mRfsh, mIdle, mEccCfg, mEccSt;
  logic [31:0] mBank [4];

  always #5 clk = ~clk;

  sdram_cfg_regs u0 (
    .clk(clk), .rst_n(rst_n), .dcrNum(dcrNum), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .sysAddr(sysAddr), .bankHit(bankHit),
    .eccIrq(eccIrq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecCnt++;
    if (got !== exp) begin
      errCnt++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic dcrWr(input logic [9:0] n, input logic [31:0] v);
    @(negedge clk);
    dcrNum = n; wrData = v; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic dcrRd(input logic [9:0] n, output logic [31:0] d);
    @(negedge clk);
    dcrNum = n; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    d = rdData;
  endtask

  function automatic logic [31:0] expRead(input logic [31:0] off);
    case (off)
      32'h00, 32'h08: return 32'h0;
      32'h10: return mErrAddr;
      32'h20: return mCfg;
      32'h24: return mStat;
      32'h30: return mRfsh;
      32'h34: return mIdle;
      32'h40: return mBank[0];
      32'h44: return mBank[1];
      32'h48: return mBank[2];
      32'h4C: return mBank[3];
      32'h94: return mEccCfg;
      32'h98: return mEccSt;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] expHit(input logic [31:0] a);
    for (int b = 0; b < 4; b++) begin
      longint unsigned base, sz;
      int code;
      code = int'(mBank[b][19:17]);
      base = longint'(mBank[b][31:23]) << 23;
      sz   = 64'd4194304 << code;
      if (mCfg[31] && mBank[b][0] && code != 7 &&
          longint'(a) >= base && longint'(a) < base + sz)
        return 4'(1 << b);
    end
    return 4'h0;
  endfunction

  task automatic regWr(input logic [31:0] off, input logic [31:0] v);
    logic [31:0] nv;
    dcrWr(PTR, off);
    mOffset = off;
    dcrWr(WIN, v);
    case (off)
      32'h10: mErrAddr = v;
      32'h20: begin
        nv = v & 32'hFFE0_0000;
        if (!mCfg[31] && nv[31]) mStat[31] = 1'b0;
        else if (mCfg[31] && !nv[31]) mStat[31] = 1'b1;
        if (!mCfg[30] && nv[30]) mStat[30] = 1'b1;
        else if (mCfg[30] && !nv[30]) mStat[30] = 1'b0;
        mCfg = nv;
      end
      32'h30: mRfsh = v & 32'h3FF8_0000;
      32'h34: mIdle = (v & 32'hF800_0000) | 32'h07C0_0000;
      32'h40: mBank[0] = v & 32'hFFDE_E001;
      32'h44: mBank[1] = v & 32'hFFDE_E001;
      32'h48: mBank[2] = v & 32'hFFDE_E001;
      32'h4C: mBank[3] = v & 32'hFFDE_E001;
      32'h94: mEccCfg = v & 32'h00F0_0000;
      32'h98: mEccSt = v & 32'hFFF0_F000;
      default: ;
    endcase
  endtask

  task automatic regChk(input string tag, input logic [31:0] off);
    logic [31:0] d;
    dcrWr(PTR, off);
    mOffset = off;
    dcrRd(WIN, d);
    check(tag, d, expRead(off));
  endtask

  task automatic hitChk(input string tag, input logic [31:0] a);
    @(negedge clk);
    sysAddr = a;
    #1;
    check(tag, 32'(bankHit), 32'(expHit(a)));
  endtask

  initial begin
    logic [31:0] d;
    int unused;
    unused = $urandom(32'h5EED);
    mOffset = 0; mErrAddr = 0; mCfg = 32'h0080_0000; mStat = 0;
    mRfsh = 32'h05F0_0000; mIdle = 32'h07C0_0000; mEccCfg = 0; mEccSt = 0;
    for (int b = 0; b < 4; b++) mBank[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    dcrRd(PTR, d);            check("R3 offset after reset", d, 32'h0);
    check("R3 irq after reset", 32'(eccIrq), 32'h0);
    regChk("R3 cfg reset", 32'h20);
    regChk("R3 refresh reset", 32'h30);
    regChk("R3 idle reset", 32'h34);
    regChk("R3 status reset", 32'h24);
    regChk("R3 bank0 reset", 32'h40);
    regChk("R3 ecc status reset", 32'h98);

    // R1 pointer port read-back
    dcrWr(PTR, 32'hDEAD_BEEF); mOffset = 32'hDEAD_BEEF;
    dcrRd(PTR, d);            check("R1 offset readback", d, 32'hDEAD_BEEF);
    // R2 unmapped, timing, misaligned bank, foreign DCR
    dcrRd(WIN, d);            check("R2 unmapped reads ones", d, 32'hFFFF_FFFF);
    regWr(32'h80, 32'h0);
    regChk("R2 timing reads ones", 32'h80);
    regChk("R2 misaligned bank offset", 32'h42);
    regChk("R2 offset past last bank", 32'h50);
    dcrRd(10'h012, d);        check("R2 foreign DCR reads zero", d, 32'h0);

    // R4 write-one-to-clear error words
    regWr(32'h00, 32'hFFFF_FFFF); regChk("R4 err0 stays clear", 32'h00);
    regWr(32'h08, 32'hA5A5_A5A5); regChk("R4 err1 stays clear", 32'h08);

    // R6, R7, R8, R5 configuration and status edges
    regWr(32'h20, 32'hFFFF_FFFF); regChk("R6 cfg masked", 32'h20);
    regChk("R7 enable rise clears status", 32'h24);
    regWr(32'h20, 32'h0);        regChk("R7 enable fall sets status", 32'h24);
    regWr(32'h24, 32'h0);        regChk("R5 status ignores write", 32'h24);
    regWr(32'h20, 32'h4000_0000); regChk("R8 aux rise sets status", 32'h24);
    regWr(32'h20, 32'h0);        regChk("R8 aux fall clears status", 32'h24);
    regWr(32'h24, 32'hFFFF_FFFF); regChk("R5 status ignores ones", 32'h24);

    // R9 masks
    regWr(32'h30, 32'hFFFF_FFFF); regChk("R9 refresh mask", 32'h30);
    regWr(32'h34, 32'h0);         regChk("R9 idle forced bits", 32'h34);
    regWr(32'h94, 32'hFFFF_FFFF); regChk("R9 ecc cfg mask", 32'h94);
    regWr(32'h10, 32'h1234_5678); regChk("R9 error address", 32'h10);

    // R10 ECC status and interrupt
    regWr(32'h98, 32'h000F_0FFF); check("R10 masked-out write no irq", 32'(eccIrq), 32'h0);
    regWr(32'h98, 32'h0000_1000); check("R10 irq raised", 32'(eccIrq), 32'h1);
    regChk("R10 ecc status value", 32'h98);
    regWr(32'h98, 32'h0);         check("R10 irq lowered", 32'(eccIrq), 32'h0);

    // R11 bank mask
    regWr(32'h4C, 32'hFFFF_FFFF); regChk("R11 bank3 mask", 32'h4C);

    // R12, R13 directed decode
    regWr(32'h20, 32'h8000_0000);
    regWr(32'h40, 32'h0080_0001);   // 8 MiB base, 4 MiB
    regWr(32'h44, 32'h0008_0001);   // base 0, 64 MiB
    regWr(32'h48, 32'hFF8C_0001);   // top of space, 256 MiB
    regWr(32'h4C, 32'h100E_0001);   // invalid size code
    hitChk("R13 overlap lowest wins", 32'h0090_0000);
    hitChk("R12 bank0 base", 32'h0080_0000);
    hitChk("R12 bank0 last byte", 32'h00BF_FFFF);
    hitChk("R12 bank0 end falls to bank1", 32'h00C0_0000);
    hitChk("R12 bank1 end", 32'h0400_0000);
    hitChk("R12 bank2 below base", 32'hFF7F_FFFF);
    hitChk("R12 bank2 top of space", 32'hFFFF_FFFF);
    hitChk("R13 size code 7 no hit", 32'h1000_0000);
    regWr(32'h40, 32'h0080_0000);
    hitChk("R12 bank disabled", 32'h0090_0000);
    regWr(32'h20, 32'h0);
    hitChk("R12 global disable", 32'h0010_0000);

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [31:0] v;
      op = $urandom_range(0, 7);
      case (op)
        0: begin
          v = $urandom;
          if ($urandom_range(0, 3) != 0) v[31] = 1'b1;
          regWr(32'h20, v);
          regChk("R7 random status", 32'h24);
        end
        1, 2: begin
          int b;
          b = $urandom_range(0, 3);
          v = $urandom;
          if ($urandom_range(0, 3) != 0) v[0] = 1'b1;
          regWr(32'h40 + 32'(4 * b), v);
          regChk("R11 random bank", 32'h40 + 32'(4 * b));
        end
        3: begin
          logic [31:0] offs [9];
          offs = '{32'h00, 32'h08, 32'h10, 32'h24, 32'h30, 32'h34, 32'h80, 32'h94, 32'h98};
          v = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
          regWr(offs[$urandom_range(0, 8)], v);
          check("R10 random irq", 32'(eccIrq), 32'(mEccSt != 0));
        end
        4, 5: begin
          int b;
          logic [31:0] a;
          b = $urandom_range(0, 3);
          a = {mBank[b][31:23], 23'h0} + ($urandom & 32'h1FFF_FFFF);
          if ($urandom_range(0, 7) == 0) a = $urandom;
          hitChk("R12 random decode", a);
        end
        6: begin
          logic [31:0] o;
          o = {24'h0, 8'($urandom) & 8'hFC};
          regChk("R2 random read", o);
          dcrRd(PTR, d);
          check("R1 random offset", d, mOffset);
        end
        default: begin
          regWr(32'h98, $urandom & 32'h0000_F000);
          check("R10 random ecc irq", 32'(eccIrq), 32'(mEccSt != 0));
        end
      endcase
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      errCnt++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

endmodule